// File: doc/BRIEF.md
# Countdown ECC Fault Injector

The block sits between the ECC encoder and the array on the write path of an ECC-protected RAM. It deliberately corrupts one stored word so that software can exercise its error-reporting path. Software first loads a corruption mask, then a countdown value. Every accepted RAM write lowers the countdown by one. When the countdown has reached zero and injection is armed, the next accepted write has its data bits XORed with the mask. The check bits are computed upstream and pass through untouched, so the stored word no longer matches its code. A mask with one set bit gives a correctable error when the word is read back. A mask with two set bits gives an uncorrectable error.

Injection fires once and then disarms. It arms again only when software writes the count register. Writes that are not corrupted pass straight through with no added latency. Software reaches the block through a 32-bit register port: writes take effect at the clock edge and reads are combinational.

Top module: `ecc_fault_injector`

## Requirements
- R1: Mask word k (k = 0..3) is read and written at byte offset 0x4C + 4*k. Word 0 holds data bits 31:0, word 1 holds bits 63:32, and words 2 and 3 hold higher bits. A word reads back exactly what was last written to it.
- R2: The count register sits at offset 0x74. Only bits 27:0 of a write are stored, and bits 31:28 read as zero.
- R3: A read of the count register returns the live countdown value, including decrements made by RAM writes.
- R4: An accepted write (valid high) that arrives while the countdown is non-zero lowers the countdown by exactly one. Its data passes through unmodified in the same cycle.
- R5: An accepted write that arrives while the countdown is zero and injection is armed leaves with its data equal to the input data XOR the mask, in the same cycle. The check bits and the valid flag are never altered.
- R6: After an injection the block is disarmed. Later writes pass unmodified and the countdown stays at zero until the count register is written again.
- R7: Writing the count register arms injection. Writing zero makes the very next accepted write the corrupted one.
- R8: After reset the countdown is zero, injection is disarmed and every mask word reads zero.
- R9: Cycles with valid low change neither the countdown nor the armed state.
- R10: Reads at unmapped offsets return zero. Writes to unmapped offsets change no register.
- R11: If a count-register write and an accepted RAM write fall in the same cycle, the register write wins. The new count is loaded without a decrement, and the RAM write is handled using the state from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| inWrValid | input | 1 | RAM write accepted this cycle |
| inWrData | input | DATA_W | Write data from the encoder |
| inWrCheck | input | CHK_W | Check bits from the encoder |
| outWrValid | output | 1 | Write valid to the array |
| outWrData | output | DATA_W | Write data to the array, possibly corrupted |
| outWrCheck | output | CHK_W | Check bits to the array |

## Verification
The bench builds the block with its defaults: a 64-bit data word, 8 check bits and a 28-bit countdown. This puts both halves of the mask inside the data word, so single-bit masks in the low word and double-bit masks in the high word can be seen at the output. Mask words 2 and 3 can still be stored and read back, but they lie above the data word and have no effect on it. A full 28-bit countdown is never run down. Instead the bench loads small counts and observes every step, the zero-count arming case, the disarm after an injection, and a count load that collides with a RAM write.

// File: rtl/efi_pkg.sv
package efi_pkg;
  localparam int REG_W      = 32;
  localparam int PAT_WORDS  = 4;
  localparam int PAT_W      = REG_W * PAT_WORDS;
  localparam int PAT_BASE   = 'h4C;
  localparam int CNT_OFS    = 'h74;

  typedef struct packed {
    logic [PAT_WORDS-1:0] patWrSel;
    logic [PAT_WORDS-1:0] patRdSel;
    logic                 injectNow;
  } efi_strobes_t;
endpackage

// File: rtl/efi_ctrl.sv
module efi_ctrl
  import efi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [CNT_W-1:0]  regCntData,
  input  logic              inWrValid,
  output efi_strobes_t      strobes,
  output logic [CNT_W-1:0]  cntValue,
  output logic              armed,
  output logic              cntRdSel
);
  logic [CNT_W-1:0] cntQ;
  logic             armedQ;
  logic             cntHit;
  logic             cntZero;

  assign cntRdSel = (regAddr == ADDR_W'(CNT_OFS));
  assign cntHit   = regWrEn && cntRdSel;
  assign cntZero  = (cntQ == '0);

  for (genvar i = 0; i < PAT_WORDS; i++) begin : g_sel
    assign strobes.patRdSel[i] = (regAddr == ADDR_W'(PAT_BASE + 4 * i));
    assign strobes.patWrSel[i] = regWrEn && strobes.patRdSel[i];
  end

  // the decision for the current write uses state from before this edge
  assign strobes.injectNow = inWrValid && armedQ && cntZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      armedQ <= 1'b0;
    end else if (cntHit) begin
      cntQ   <= regCntData;
      armedQ <= 1'b1;
    end else if (inWrValid && !cntZero) begin
      cntQ   <= cntQ - CNT_W'(1);
    end else if (strobes.injectNow) begin
      armedQ <= 1'b0;
    end
  end

  assign cntValue = cntQ;
  assign armed    = armedQ;
endmodule

// File: rtl/efi_datapath.sv
module efi_datapath
  import efi_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  efi_strobes_t      strobes,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [DATA_W-1:0] inWrData,
  input  logic [CHK_W-1:0]  inWrCheck,
  output logic [DATA_W-1:0] outWrData,
  output logic [CHK_W-1:0]  outWrCheck,
  output logic [REG_W-1:0]  patRdData
);
  logic [PAT_W-1:0] patFull;

  for (genvar i = 0; i < PAT_WORDS; i++) begin : g_word
    logic [REG_W-1:0] wordQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) wordQ <= '0;
      else if (strobes.patWrSel[i]) wordQ <= regWrData;
    end
    assign patFull[i*REG_W +: REG_W] = wordQ;
  end

  always_comb begin
    patRdData = '0;
    for (int i = 0; i < PAT_WORDS; i++) begin
      if (strobes.patRdSel[i]) patRdData = patRdData | patFull[i*REG_W +: REG_W];
    end
  end

  assign outWrData  = strobes.injectNow ? (inWrData ^ patFull[DATA_W-1:0]) : inWrData;
  assign outWrCheck = inWrCheck;
endmodule

// File: rtl/ecc_fault_injector.sv
module ecc_fault_injector
  import efi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 64,
  parameter int CHK_W  = 8,
  parameter int CNT_W  = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              inWrValid,
  input  logic [DATA_W-1:0] inWrData,
  input  logic [CHK_W-1:0]  inWrCheck,
  output logic              outWrValid,
  output logic [DATA_W-1:0] outWrData,
  output logic [CHK_W-1:0]  outWrCheck
);
  efi_strobes_t     strobes;
  logic [CNT_W-1:0] cntValue;
  logic             armed;
  logic             cntRdSel;
  logic [REG_W-1:0] patRdData;

  efi_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .regCntData (regWrData[CNT_W-1:0]),
    .inWrValid  (inWrValid),
    .strobes    (strobes),
    .cntValue   (cntValue),
    .armed      (armed),
    .cntRdSel   (cntRdSel)
  );

  efi_datapath #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .regWrData  (regWrData),
    .inWrData   (inWrData),
    .inWrCheck  (inWrCheck),
    .outWrData  (outWrData),
    .outWrCheck (outWrCheck),
    .patRdData  (patRdData)
  );

  assign outWrValid = inWrValid;
  assign regRdData  = cntRdSel ? {{(REG_W-CNT_W){1'b0}}, cntValue} : patRdData;
endmodule

// File: rtl/efi_checker.sv
module efi_checker
  import efi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 64,
  parameter int CHK_W  = 8,
  parameter int CNT_W  = 28
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [31:0]       regWrData,
  input logic              inWrValid,
  input logic [DATA_W-1:0] inWrData,
  input logic [CHK_W-1:0]  inWrCheck,
  input logic              outWrValid,
  input logic [DATA_W-1:0] outWrData,
  input logic [CHK_W-1:0]  outWrCheck,
  input logic [CNT_W-1:0]  cntValue,
  input logic              armed
);
  logic cntWr;
  assign cntWr = regWrEn && (regAddr == ADDR_W'(CNT_OFS));

  // R4
  dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inWrValid && cntValue != '0 && !cntWr) |=> cntValue == $past(cntValue) - CNT_W'(1));

  // R4
  pass_counting_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntValue != '0) |-> outWrData == inWrData);

  // R5
  side_passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outWrCheck == inWrCheck) && (outWrValid == inWrValid));

  // R6
  disarm_after_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inWrValid && armed && cntValue == '0 && !cntWr) |=> !armed);

  // R6
  pass_disarmed_chk: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> outWrData == inWrData);

  // R7
  arm_on_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> armed && cntValue == $past(regWrData[CNT_W-1:0]));

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inWrValid && !cntWr) |=> $stable(cntValue) && $stable(armed));
endmodule

bind ecc_fault_injector efi_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHK_W(CHK_W), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regAddr    (regAddr),
  .regWrEn    (regWrEn),
  .regWrData  (regWrData),
  .inWrValid  (inWrValid),
  .inWrData   (inWrData),
  .inWrCheck  (inWrCheck),
  .outWrValid (outWrValid),
  .outWrData  (outWrData),
  .outWrCheck (outWrCheck),
  .cntValue   (cntValue),
  .armed      (armed)
);

// File: tb/ecc_fault_injector_test.sv
module ecc_fault_injector_test;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int CNT_W  = 28;

  // kinds: 0 reg write, 1 reg read check, 2 stream write check, 3 idle cycle
  typedef struct packed {
    logic [1:0]  kind;
    logic [7:0]  addr;
    logic [63:0] arg;
    logic [63:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 33;
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 8'h74, 64'h0, 64'h0, 4'd8},                                   // R8 count zero
    '{2'd1, 8'h4C, 64'h0, 64'h0, 4'd8},                                   // R8 mask zero
    '{2'd2, 8'h00, 64'h1111_2222_3333_4444, 64'h1111_2222_3333_4444, 4'd8}, // R8 no injection
    '{2'd0, 8'h4C, 64'h0000_0010, 64'h0, 4'd1},
    '{2'd0, 8'h50, 64'h0, 64'h0, 4'd1},
    '{2'd1, 8'h4C, 64'h0, 64'h10, 4'd1},                                  // R1
    '{2'd0, 8'h74, 64'hF000_0003, 64'h0, 4'd2},
    '{2'd1, 8'h74, 64'h0, 64'h3, 4'd2},                                   // R2 upper bits dropped
    '{2'd2, 8'h00, 64'hAAAA_0000_0000_0001, 64'hAAAA_0000_0000_0001, 4'd4}, // R4
    '{2'd1, 8'h74, 64'h0, 64'h2, 4'd3},                                   // R3 live count
    '{2'd2, 8'h00, 64'h0000_0000_FFFF_0000, 64'h0000_0000_FFFF_0000, 4'd4}, // R4
    '{2'd2, 8'h00, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 4'd4}, // R4
    '{2'd1, 8'h74, 64'h0, 64'h0, 4'd3},                                   // R3
    '{2'd2, 8'h00, 64'h5555_5555_5555_5555, 64'h5555_5555_5555_5545, 4'd5}, // R5 single bit 4
    '{2'd2, 8'h00, 64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555, 4'd6}, // R6 disarmed
    '{2'd1, 8'h74, 64'h0, 64'h0, 4'd6},                                   // R6 stays zero
    '{2'd0, 8'h4C, 64'h0, 64'h0, 4'd5},
    '{2'd0, 8'h50, 64'h8000_0001, 64'h0, 4'd5},
    '{2'd1, 8'h50, 64'h0, 64'h8000_0001, 4'd1},                           // R1 high word
    '{2'd0, 8'h74, 64'h0, 64'h0, 4'd7},
    '{2'd2, 8'h00, 64'h0, 64'h8000_0001_0000_0000, 4'd7},                 // R7 zero count arms, double bit
    '{2'd2, 8'h00, 64'h0, 64'h0, 4'd6},                                   // R6
    '{2'd0, 8'h54, 64'hDEAD_BEEF, 64'h0, 4'd1},
    '{2'd1, 8'h54, 64'h0, 64'hDEAD_BEEF, 4'd1},                           // R1 word 2
    '{2'd0, 8'h58, 64'h1234_5678, 64'h0, 4'd1},
    '{2'd1, 8'h58, 64'h0, 64'h1234_5678, 4'd1},                           // R1 word 3
    '{2'd1, 8'h60, 64'h0, 64'h0, 4'd10},                                  // R10 unmapped read
    '{2'd0, 8'h60, 64'hFFFF_FFFF, 64'h0, 4'd10},
    '{2'd1, 8'h74, 64'h0, 64'h0, 4'd10},                                  // R10 count untouched
    '{2'd0, 8'h74, 64'h2, 64'h0, 4'd9},
    '{2'd3, 8'h00, 64'h0, 64'h0, 4'd9},
    '{2'd3, 8'h00, 64'h0, 64'h0, 4'd9},
    '{2'd1, 8'h74, 64'h0, 64'h2, 4'd9}                                    // R9 idle keeps count
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic              regWrEn = 1'b0;
  logic [31:0]       regWrData = '0;
  logic [31:0]       regRdData;
  logic              inWrValid = 1'b0;
  logic [DATA_W-1:0] inWrData = '0;
  logic [CHK_W-1:0]  inWrCheck = '0;
  logic              outWrValid;
  logic [DATA_W-1:0] outWrData;
  logic [CHK_W-1:0]  outWrCheck;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ecc_fault_injector #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHK_W(CHK_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .inWrValid(inWrValid), .inWrData(inWrData), .inWrCheck(inWrCheck),
    .outWrValid(outWrValid), .outWrData(outWrData), .outWrCheck(outWrCheck)
  );

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clearInputs();
    regWrEn = 1'b0; inWrValid = 1'b0; regAddr = '0; regWrData = '0; inWrData = '0;
  endtask

  task automatic applyVec(input vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.req);
    @(negedge clk);
    clearInputs();
    case (v.kind)
      2'd0: begin regAddr = v.addr; regWrEn = 1'b1; regWrData = v.arg[31:0]; end
      2'd1: begin regAddr = v.addr; #1; check64(tag, {32'h0, regRdData}, v.exp); end
      2'd2: begin
        inWrValid = 1'b1; inWrData = v.arg; inWrCheck = v.arg[7:0] ^ 8'h5A;
        #1;
        check64(tag, outWrData, v.exp);
        check64({tag, " side"}, {55'h0, outWrValid, outWrCheck}, {55'h0, 1'b1, v.arg[7:0] ^ 8'h5A});
      end
      default: ;
    endcase
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < NVEC; i++) applyVec(VECS[i]);

    // R11: count load collides with an accepted write; count is 2, so data passes
    @(negedge clk);
    clearInputs();
    regAddr = 8'h74; regWrEn = 1'b1; regWrData = 32'h5;
    inWrValid = 1'b1; inWrData = 64'hCAFE_F00D_0000_0001;
    #1;
    check64("R11 data", outWrData, 64'hCAFE_F00D_0000_0001);
    @(negedge clk);
    clearInputs();
    regAddr = 8'h74;
    #1;
    check64("R11 count", {32'h0, regRdData}, 64'h5);

    // R11: collision while armed at zero; old state injects, new count loads
    @(negedge clk);
    clearInputs();
    regAddr = 8'h74; regWrEn = 1'b1; regWrData = 32'h0;
    @(negedge clk);
    clearInputs();
    regAddr = 8'h74; regWrEn = 1'b1; regWrData = 32'h7;
    inWrValid = 1'b1; inWrData = 64'h0;
    #1;
    check64("R11 inject", outWrData, 64'h8000_0001_0000_0000);
    @(negedge clk);
    clearInputs();
    regAddr = 8'h74;
    #1;
    check64("R11 reload", {32'h0, regRdData}, 64'h7);

    // R8: reset while armed at zero clears everything
    @(negedge clk);
    clearInputs();
    regAddr = 8'h74; regWrEn = 1'b1; regWrData = 32'h0;
    @(negedge clk);
    clearInputs();
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    inWrValid = 1'b1; inWrData = 64'h0;
    #1;
    check64("R8 post-reset data", outWrData, 64'h0);
    @(negedge clk);
    clearInputs();
    regAddr = 8'h50;
    #1;
    check64("R8 post-reset mask", {32'h0, regRdData}, 64'h0);

    @(negedge clk);
    clearInputs();
    finish();
  end
endmodule